// File: doc/BRIEF.md
# Memory Reclaim Address Remapper

This block sits at the front of a memory controller and classifies every incoming logical address of an 8 GB (33-bit) space. Below 4 GB, the range between the top of low DRAM and the 4 GB line is taken by memory-mapped I/O. The DRAM that lies under that hole would otherwise be lost, so the block can relocate it into a programmable window above the top of memory. An address inside that window is redirected to the hidden DRAM at the same offset.

Five configuration fields are loaded through a simple write port: the low DRAM top, the upper DRAM top, the window base, the window limit and the window enable. The decode is combinational from the registered fields, so a classification and a physical address come out in every cycle. When the window is enabled, the low DRAM top must sit on a 64 MB boundary. If it does not, the block raises a configuration error and does not remap.

Top module: `mem_reclaim_remap`

## Requirements
- R1: A write (wr_en high) is captured at the next rising clock edge and changes the decode only from that edge onward. Reset clears every field and disables the window. After reset, every address decodes as I/O and cfg_err is low.
- R2: An address below the low DRAM top decodes as DRAM (dram_hit=1, mmio_hit=0) with phys_addr equal to the address.
- R3: An address at or above the low DRAM top and below 4 GB decodes as I/O (mmio_hit=1, dram_hit=0).
- R4: With the window enabled and no configuration error, an address at or above 4 GB that lies from the window base up to the last byte of the 64 MB block named by the window limit decodes as DRAM. Its phys_addr is address minus window base plus low DRAM top. This takes precedence over R6.
- R5: A window address whose remapped result reaches 4 GB or more decodes as I/O.
- R6: An address from 4 GB up to, but not including, the upper DRAM top decodes as DRAM with phys_addr equal to the address.
- R7: With the window disabled, window addresses are not remapped and decode by the R6 and R9 rules.
- R8: cfg_err is high exactly when the window is enabled and bits 25:20 of the low DRAM top are not all zero. In that case no address is remapped. With the window disabled, a low DRAM top on any 1 MB boundary is accepted.
- R9: Any address not claimed by R2, R4 or R6 decodes as I/O with phys_addr equal to the address. dram_hit and mmio_hit are never equal.
- R10: Field selects on wr_sel are as follows: 0 sets the low DRAM top from wr_data[31:20]; 1 sets the upper top from wr_data[32:20]; 2 sets the window base and 3 the window limit, each from wr_data[32:26]; 4 sets the enable from wr_data[0]. Select codes 5 to 7 and all other data bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 33 | Write data, address-aligned |
| addr | input | 33 | Logical address to decode |
| phys_addr | output | 33 | Physical DRAM address (the address itself when not remapped) |
| dram_hit | output | 1 | Address targets DRAM |
| mmio_hit | output | 1 | Address targets I/O or is unclaimed |
| cfg_err | output | 1 | Window enabled with a low top that is not 64 MB aligned |

## Verification
The bench sweeps the whole 8 GB space at both ends of every 1 MB block under six configurations and compares the results against an arithmetic model. The configurations cover a working window, a disabled window, a misaligned low top with and without the enable, a window larger than the hole, and a window that overlaps the upper DRAM range.

Each configuration targets a likely fault:
- An off-by-one on the inclusive limit would drop or add the last megabyte of the window.
- A wrong remap offset would send window addresses to the wrong DRAM.
- Missing overflow handling would alias window addresses above 4 GB of physical space.
- Checking alignment unconditionally would flag errors on legal 1 MB-aligned setups.
- Reversed priority would pass overlapped window addresses through unremapped.

A write-timing check and writes with unused select codes and data bits confirm that configuration lands one edge later and only where it is meant to.

// File: rtl/mrr_pkg.sv
package mrr_pkg;
  localparam int AW       = 33;  // logical address width (8 GB)
  localparam int LT_LSB   = 20;  // 1 MB granularity
  localparam int LT_MSB   = 31;  // low top stays below 4 GB
  localparam int WIN_LSB  = 26;  // 64 MB granularity
  localparam int HOLE_BIT = 32;  // 4 GB boundary

  typedef logic [AW-1:0] addr_t;

  typedef enum logic [2:0] {
    RG_LOW     = 3'd0,
    RG_HOLE    = 3'd1,
    RG_WIN     = 3'd2,
    RG_WIN_OVF = 3'd3,
    RG_UPPER   = 3'd4,
    RG_NONE    = 3'd5
  } region_e;

  localparam addr_t BOUNDARY = addr_t'(1) << HOLE_BIT;

  // remapped target: offset into the window added to the low top, one bit wider
  function automatic logic [AW:0] remap_target(addr_t a, addr_t win_lo, addr_t low_top);
    return ({1'b0, a} - {1'b0, win_lo}) + {1'b0, low_top};
  endfunction

  function automatic logic region_is_dram(region_e r);
    return (r == RG_LOW) || (r == RG_WIN) || (r == RG_UPPER);
  endfunction

  function automatic logic region_is_mmio(region_e r);
    return (r == RG_HOLE) || (r == RG_WIN_OVF) || (r == RG_NONE);
  endfunction
endpackage

// File: rtl/mrr_cfg_regs.sv
module mrr_cfg_regs
  import mrr_pkg::*;
#(
  parameter int W    = AW,
  parameter int LTL  = LT_LSB,
  parameter int LTM  = LT_MSB,
  parameter int WNL  = WIN_LSB
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] low_a,
  output logic [W-1:0] up_a,
  output logic [W-1:0] win_lo_a,
  output logic [W-1:0] win_hi_a,
  output logic         rcl_en,
  output logic         cfg_err
);
  localparam int LT_W  = LTM - LTL + 1;
  localparam int UT_W  = W - LTL;
  localparam int WN_W  = W - WNL;
  localparam int PAD_W = W - 1 - LTM;
  localparam int SUB_W = WNL - LTL;

  logic [LT_W-1:0] lt_q;
  logic [UT_W-1:0] ut_q;
  logic [WN_W-1:0] wb_q;
  logic [WN_W-1:0] wl_q;
  logic            en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lt_q <= '0;
      ut_q <= '0;
      wb_q <= '0;
      wl_q <= '0;
      en_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        3'd0:    lt_q <= wr_data[LTM:LTL];
        3'd1:    ut_q <= wr_data[W-1:LTL];
        3'd2:    wb_q <= wr_data[W-1:WNL];
        3'd3:    wl_q <= wr_data[W-1:WNL];
        3'd4:    en_q <= wr_data[0];
        default: ;
      endcase
    end
  end

  logic unused_data;
  assign unused_data = ^wr_data[LTL-1:1];

  assign low_a    = {{PAD_W{1'b0}}, lt_q, {LTL{1'b0}}};
  assign up_a     = {ut_q, {LTL{1'b0}}};
  assign win_lo_a = {wb_q, {WNL{1'b0}}};
  assign win_hi_a = {wl_q, {WNL{1'b1}}};
  assign rcl_en   = en_q;
  assign cfg_err  = en_q && (lt_q[SUB_W-1:0] != '0);
endmodule

// File: rtl/mrr_decode.sv
module mrr_decode
  import mrr_pkg::*;
(
  input  addr_t   addr,
  input  addr_t   low_a,
  input  addr_t   up_a,
  input  addr_t   win_lo_a,
  input  addr_t   win_hi_a,
  input  logic    remap_ok,
  output region_e region,
  output addr_t   phys
);
  logic          below_low;
  logic          below_bound;
  logic          in_win;
  logic          in_upper;
  logic [AW:0]   target;
  logic          target_fits;

  assign below_low   = addr < low_a;
  assign below_bound = addr < BOUNDARY;
  assign in_win      = remap_ok && (addr >= win_lo_a) && (addr <= win_hi_a);
  assign in_upper    = (addr < up_a);
  assign target      = remap_target(addr, win_lo_a, low_a);
  assign target_fits = target < {1'b0, BOUNDARY};

  always_comb begin
    region = RG_NONE;
    phys   = addr;
    if (below_low) begin
      region = RG_LOW;
    end else if (below_bound) begin
      region = RG_HOLE;
    end else if (in_win) begin
      if (target_fits) begin
        region = RG_WIN;
        phys   = target[AW-1:0];
      end else begin
        region = RG_WIN_OVF;
      end
    end else if (in_upper) begin
      region = RG_UPPER;
    end
  end
endmodule

// File: rtl/mem_reclaim_remap.sv
module mem_reclaim_remap
  import mrr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] phys_addr,
  output logic          dram_hit,
  output logic          mmio_hit,
  output logic          cfg_err
);
  addr_t   low_a, up_a, win_lo_a, win_hi_a;
  logic    rcl_en;
  logic    remap_ok;
  region_e region;

  mrr_cfg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .low_a    (low_a),
    .up_a     (up_a),
    .win_lo_a (win_lo_a),
    .win_hi_a (win_hi_a),
    .rcl_en   (rcl_en),
    .cfg_err  (cfg_err)
  );

  assign remap_ok = rcl_en && !cfg_err;

  mrr_decode u_dec (
    .addr     (addr),
    .low_a    (low_a),
    .up_a     (up_a),
    .win_lo_a (win_lo_a),
    .win_hi_a (win_hi_a),
    .remap_ok (remap_ok),
    .region   (region),
    .phys     (phys_addr)
  );

  assign dram_hit = region_is_dram(region);
  assign mmio_hit = region_is_mmio(region);
endmodule

// File: rtl/mrr_checker.sv
module mrr_checker
  import mrr_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    wr_en,
  input logic [2:0] wr_sel,
  input addr_t   wr_data,
  input addr_t   addr,
  input addr_t   phys_addr,
  input logic    dram_hit,
  input logic    mmio_hit,
  input logic    cfg_err,
  input logic    rcl_en,
  input addr_t   low_a,
  input region_e region
);
  // R2: below the low top is DRAM at the same address
  p_low_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr < low_a) |-> (dram_hit && phys_addr == addr));

  // R3: hole under 4 GB is I/O
  p_hole_mmio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= low_a && addr < BOUNDARY) |-> (mmio_hit && !dram_hit));

  // R4, R5: a remapped address lands in the hidden range under 4 GB
  p_win_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_WIN) |-> (dram_hit && phys_addr >= low_a && phys_addr < BOUNDARY));

  // R8: a configuration error suppresses remapping
  p_err_noremap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (region != RG_WIN));

  // R7: a disabled window never remaps
  p_off_noremap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rcl_en |-> (region != RG_WIN && !cfg_err));

  // R9: exactly one classification
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dram_hit != mmio_hit);

  // R1: a low-top write is visible after the edge that captures it
  p_write_lt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(wr_sel) == 3'd0) |->
      (low_a[LT_MSB:LT_LSB] == $past(wr_data[LT_MSB:LT_LSB])));
endmodule

bind mem_reclaim_remap mrr_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .addr      (addr),
  .phys_addr (phys_addr),
  .dram_hit  (dram_hit),
  .mmio_hit  (mmio_hit),
  .cfg_err   (cfg_err),
  .rcl_en    (rcl_en),
  .low_a     (low_a),
  .region    (region)
);

// File: tb/tb_mem_reclaim_remap.sv
module tb_mem_reclaim_remap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [32:0] wr_data = '0;
  logic [32:0] addr = '0;
  logic [32:0] phys_addr;
  logic        dram_hit, mmio_hit, cfg_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  longint c_low, c_up, c_base, c_lim;
  bit     c_en;

  localparam longint MB    = 64'h10_0000;
  localparam longint BLK   = 64'h400_0000;
  localparam longint G4    = 64'h1_0000_0000;
  localparam longint MASK  = 64'h1_FFFF_FFFF;

  always #2 clk = ~clk;

  mem_reclaim_remap dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .addr(addr), .phys_addr(phys_addr), .dram_hit(dram_hit), .mmio_hit(mmio_hit),
    .cfg_err(cfg_err)
  );

  task automatic check_bit(string req, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic wr(input int sel, input longint data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel[2:0]; wr_data = data[32:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_cfg(longint lo, longint up, longint b, longint l, bit en);
    c_low = lo; c_up = up; c_base = b; c_lim = l; c_en = en;
    wr(0, lo); wr(1, up); wr(2, b); wr(3, l); wr(4, longint'(en));
  endtask

  // model from the requirements
  task automatic model(input longint a, output bit dram, output longint ph,
                       output bit err, output string req);
    longint lo, up, wlo, whi, t;
    lo  = c_low & 64'hFFF0_0000;
    up  = c_up & 64'h1_FFF0_0000;
    wlo = (c_base & MASK) / BLK * BLK;
    whi = ((c_lim & MASK) / BLK * BLK) + BLK - 1;
    err = c_en && (lo % BLK != 0);
    ph  = a;
    if (a < lo) begin dram = 1; req = "R2"; end
    else if (a < G4) begin dram = 0; req = "R3"; end
    else if (c_en && !err && a >= wlo && a <= whi) begin
      t = a - wlo + lo;
      if (t < G4) begin dram = 1; ph = t; req = "R4"; end
      else begin dram = 0; req = "R5"; end
    end
    else if (a < up) begin dram = 1; req = (c_en ? "R6" : "R7"); end
    else begin dram = 0; req = (c_en ? "R9" : "R7"); end
  endtask

  task automatic check_addr(longint a);
    bit d, e; longint ph; string req;
    addr = a[32:0];
    #1;
    model(a, d, ph, e, req);
    checks++;
    if (dram_hit !== d || mmio_hit !== !d || longint'(phys_addr) != ph) begin
      fails++;
      $display("FAIL %s addr=%h actual dram=%0b mmio=%0b phys=%h expected dram=%0b mmio=%0b phys=%h",
               req, a, dram_hit, mmio_hit, phys_addr, d, !d, ph);
    end
  endtask

  task automatic sweep(string tag);
    bit d, e; longint ph; string req;
    model(0, d, ph, e, req);
    check_bit("R8", {tag, " cfg_err"}, cfg_err, e);
    for (int k = 0; k < 8192; k++) begin
      check_addr(longint'(k) * MB);
      check_addr(longint'(k) * MB + MB - 1);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    c_low = 0; c_up = 0; c_base = 0; c_lim = 0; c_en = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check_bit("R1", "reset dram_hit", dram_hit, 1'b0);
    check_bit("R1", "reset mmio_hit", mmio_hit, 1'b1);
    check_bit("R1", "reset cfg_err", cfg_err, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R1: write lands at the next edge only
    @(negedge clk);
    addr = 33'h0_1000_0000;
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 33'h0_4000_0000;
    #1 check_bit("R1", "before edge", dram_hit, 1'b0);
    @(posedge clk); #1;
    check_bit("R1", "after edge", dram_hit, 1'b1);
    @(negedge clk); wr_en = 1'b0;

    // A: working window, 1 GB hole relocated to 6..7 GB (R4, R6)
    set_cfg(64'hC000_0000, 64'h1_8000_0000, 64'h1_8000_0000, 64'h1_BC00_0000, 1);
    sweep("A");
    // R10: unused selects and data bits change nothing
    wr(5, MASK); wr(6, MASK); wr(7, MASK);
    wr(0, 64'hC00F_FFFF);
    check_addr(64'hBFFF_FFFF);
    check_addr(64'hC000_0000);
    check_addr(64'h1_7FFF_FFFF);
    check_addr(64'h1_8000_0000);
    check_addr(64'h1_BFFF_FFFF);
    check_addr(64'h1_C000_0000);
    check_bit("R10", "cfg_err after stray writes", cfg_err, 1'b0);
    // B: window disabled (R7)
    set_cfg(64'hC000_0000, 64'h1_8000_0000, 64'h1_8000_0000, 64'h1_BC00_0000, 0);
    sweep("B");
    // C: misaligned low top with window on (R8)
    set_cfg(64'hC010_0000, 64'h1_8000_0000, 64'h1_8000_0000, 64'h1_BC00_0000, 1);
    sweep("C");
    // D: misaligned low top accepted with window off (R8)
    set_cfg(64'hC010_0000, 64'h1_8000_0000, 64'h1_8000_0000, 64'h1_BC00_0000, 0);
    sweep("D");
    // E: window larger than hole (R5)
    set_cfg(64'hE000_0000, 64'h1_0000_0000, 64'h1_0000_0000, 64'h1_3C00_0000, 1);
    sweep("E");
    // F: window overlaps the upper DRAM range, window wins (R4, R6)
    set_cfg(64'hC000_0000, 64'h1_C000_0000, 64'h1_8000_0000, 64'h1_BC00_0000, 1);
    sweep("F");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule